// File: doc/BRIEF.md
# Slow-Domain Real-Time Clock with Delayed Register Writes

This block is a real-time clock that sits on a simple word bus. It keeps a 64-bit time value: a 32-bit seconds word and a 32-bit fraction word. The fraction advances on a tick-enable input, and the seconds word carries when the fraction wraps. A 64-bit alarm compare raises an alarm flag when the time equals it. Control, status and interrupt-enable words complete the register set. One interrupt line combines the enabled flags.

Every bus write is modelled as crossing into a slow timekeeping domain. A write engine holds the accepted write for a fixed number of cycles before it lands. While a write is pending, status reports it as busy. Software polls the write-complete and write-error flags to learn how a write ended. A write that arrives while another is pending is dropped and flagged as an error. After reset the clock is invalid. The counter stays frozen until software validates the clock, sets the run bit and writes the seconds word once.

The write engine has three states. WS_IDLE accepts a request and moves to WS_HOLD. WS_HOLD counts down the hold cycles and moves to WS_LAND when its count reaches zero. WS_LAND applies the write and returns to WS_IDLE. The transition from WS_HOLD to WS_LAND raises the write-next flag.

Top module: `rtc_keeper`

## Requirements
- R1: After reset the status word reads 0x0000_0002 (only the non-valid bit, bit 1, is set). Control, interrupt enable, both time words and the alarm fraction word read zero. The alarm seconds word reads 0xFFFF_FFFF, and `irq` is low.
- R2: A write is accepted on a clock edge where `bus_sel` and `bus_wr` are high and no write is pending. Its target register changes exactly LATENCY edges later (4 by default). Status bit 10 (busy) reads 1 from the accepting edge until the landing edge.
- R3: Status bit 9 (write next) becomes 1 one edge before a write lands. Status bit 8 (write complete) becomes 1 on the landing edge and never rises at any other time.
- R4: A write request that arrives while a write is pending is dropped and sets status bit 7 (write error). The pending write still lands with its own data.
- R5: Writing 1 to status bits 9, 8, 7 or 4 clears those flags when the status write lands. A status write with bit 8 set leaves write complete clear. Every other landed write sets write complete.
- R6: The non-valid flag (bit 1) clears only when a landed status write has both bit 1 and bit 0 set. Bit 0 (security violation) clears when bit 0 is written alone. A pulse on `violation_in` sets both flags.
- R7: The time value holds still unless all three conditions are met: control bit 3 is 1, the clock is valid, and the seconds word has been written since the clock last became valid. A zero write to the seconds word counts.
- R8: While the counter runs, each cycle with `tick_en` high adds one to the fraction word. When the fraction wraps from 0xFFFF_FFFF to 0, the seconds word adds one.
- R9: Status bit 4 (alarm) is set on the edge after the 64-bit time equals the 64-bit alarm value. An alarm seconds word of 0xFFFF_FFFF never raises the flag.
- R10: `irq` is high exactly when at least one of status bits 9, 8, 7 or 4 is set together with the interrupt-enable bit at the same position. The enable word keeps only those four bits.
- R11: The word addresses are 0 seconds, 1 fraction, 2 alarm seconds, 3 alarm fraction, 4 control, 5 status and 6 interrupt enable. A write to address 7 completes normally but changes nothing, and address 7 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timekeeping clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus select |
| bus_wr | input | 1 | Write strobe, valid with bus_sel |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tick_en | input | 1 | Fraction tick enable |
| violation_in | input | 1 | External security violation pulse |
| irq | output | 1 | Interrupt request |

## Verification
The bench times the write engine cycle by cycle and checks the busy, next and complete flags on each edge. A randomly placed second write, at gaps that straddle the end of the hold window, separates dropped writes from accepted ones through both the stored value and the error flag. Random data written to each mapped register and read back shows which bits each register keeps. Directed cases cover the invalid and unwritten-seconds freezes, the run-bit gate, the fraction wrap, an alarm match against a disabled alarm, the interrupt masking and the unmapped address.

// File: rtl/rtc_keeper_pkg.sv
package rtc_keeper_pkg;

    // word indices on the bus
    localparam int unsigned IDX_TSEC = 0;
    localparam int unsigned IDX_TFRAC = 1;
    localparam int unsigned IDX_AHI = 2;
    localparam int unsigned IDX_ALO = 3;
    localparam int unsigned IDX_CTRL = 4;
    localparam int unsigned IDX_STAT = 5;
    localparam int unsigned IDX_IEN = 6;

    // bit positions shared by status and interrupt enable
    localparam int unsigned B_BUSY = 10;
    localparam int unsigned B_NEXT = 9;
    localparam int unsigned B_DONE = 8;
    localparam int unsigned B_ERR = 7;
    localparam int unsigned B_ALARM = 4;
    localparam int unsigned B_NV = 1;
    localparam int unsigned B_SV = 0;

    // control word
    localparam int unsigned B_RUN = 3;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_HOLD,
        WS_LAND
    } wstate_t;

endpackage

// File: rtl/rtc_write_engine.sv
module rtc_write_engine
    import rtc_keeper_pkg::*;
#(
    parameter int LATENCY = 4,
    parameter int AW = 3,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          busy,
    output logic          commit,
    output logic [AW-1:0] commit_addr,
    output logic [DW-1:0] commit_data,
    output logic          next_evt,
    output logic          reject_evt
);

    localparam int CW = (LATENCY > 2) ? $clog2(LATENCY) : 1;
    localparam logic [CW-1:0] HOLD_LOAD = CW'(LATENCY - 2);

    wstate_t       state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          accept;

    assign accept = req_valid && (state_q == WS_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
            cnt_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (accept) begin
                addr_q <= req_addr;
                data_q <= req_data;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            WS_IDLE: begin
                if (req_valid) begin
                    state_d = WS_HOLD;
                    cnt_d   = HOLD_LOAD;
                end
            end
            WS_HOLD: begin
                if (cnt_q == '0) begin
                    state_d = WS_LAND;
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
            WS_LAND: begin
                state_d = WS_IDLE;
            end
            default: begin
                state_d = WS_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        busy       = 1'b0;
        commit     = 1'b0;
        next_evt   = 1'b0;
        reject_evt = 1'b0;
        unique case (state_q)
            WS_IDLE: begin
                busy = 1'b0;
            end
            WS_HOLD: begin
                busy       = 1'b1;
                next_evt   = (cnt_q == '0);
                reject_evt = req_valid;
            end
            WS_LAND: begin
                busy       = 1'b1;
                commit     = 1'b1;
                reject_evt = req_valid;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    assign commit_addr = addr_q;
    assign commit_data = data_q;

endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          run_en,
    input  logic          invalid,
    input  logic          load_sec,
    input  logic          load_frac,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] sec_q,
    output logic [DW-1:0] frac_q,
    output logic          armed_q
);

    logic advance;
    logic carry;

    assign advance = tick_en && run_en && armed_q;
    assign carry   = advance && (frac_q == '1);

    // arming: the seconds word must be written once while valid
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (invalid) begin
            armed_q <= 1'b0;
        end else if (load_sec) begin
            armed_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frac_q <= '0;
        end else if (load_frac) begin
            frac_q <= wdata;
        end else if (advance) begin
            frac_q <= frac_q + DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q <= '0;
        end else if (load_sec) begin
            sec_q <= wdata;
        end else if (carry) begin
            sec_q <= sec_q + DW'(1);
        end
    end

endmodule

// File: rtl/rtc_status_regs.sv
module rtc_status_regs
    import rtc_keeper_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic          stat_wr,
    input  logic [DW-1:0] wdata,
    input  logic          next_evt,
    input  logic          reject_evt,
    input  logic          alarm_hit,
    input  logic          violation,
    output logic          f_next,
    output logic          f_done,
    output logic          f_err,
    output logic          f_alarm,
    output logic          f_nv,
    output logic          f_sv
);

    logic clr_next, clr_done, clr_err, clr_alarm, clr_sv, clr_nv;

    assign clr_next  = stat_wr && wdata[B_NEXT];
    assign clr_done  = stat_wr && wdata[B_DONE];
    assign clr_err   = stat_wr && wdata[B_ERR];
    assign clr_alarm = stat_wr && wdata[B_ALARM];
    assign clr_sv    = stat_wr && wdata[B_SV];
    assign clr_nv    = stat_wr && wdata[B_SV] && wdata[B_NV];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_next  <= 1'b0;
            f_done  <= 1'b0;
            f_err   <= 1'b0;
            f_alarm <= 1'b0;
            f_nv    <= 1'b1;
            f_sv    <= 1'b0;
        end else begin
            if (next_evt) f_next <= 1'b1;
            else if (clr_next) f_next <= 1'b0;

            if (clr_done) f_done <= 1'b0;
            else if (commit) f_done <= 1'b1;

            if (reject_evt) f_err <= 1'b1;
            else if (clr_err) f_err <= 1'b0;

            if (alarm_hit) f_alarm <= 1'b1;
            else if (clr_alarm) f_alarm <= 1'b0;

            if (violation) f_sv <= 1'b1;
            else if (clr_sv) f_sv <= 1'b0;

            if (violation) f_nv <= 1'b1;
            else if (clr_nv) f_nv <= 1'b0;
        end
    end

endmodule

// File: rtl/rtc_keeper.sv
module rtc_keeper
    import rtc_keeper_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 3,
    parameter int LATENCY = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          tick_en,
    input  logic          violation_in,
    output logic          irq
);

    localparam logic [DW-1:0] IEN_MASK = (DW'(1) << B_NEXT) | (DW'(1) << B_DONE)
                                       | (DW'(1) << B_ERR) | (DW'(1) << B_ALARM);

    logic          eng_busy, eng_commit, eng_next, eng_reject;
    logic [AW-1:0] eng_addr;
    logic [DW-1:0] eng_data;

    logic          ctrl_run_q;
    logic [DW-1:0] alarm_hi_q, alarm_lo_q, ien_q;
    logic [DW-1:0] time_sec, time_frac;
    logic          time_armed;

    logic          flag_next, flag_done, flag_err, flag_alarm, flag_nv, flag_sv;
    logic          alarm_hit;
    logic [DW-1:0] stat_word;

    logic          wr_tsec, wr_tfrac, wr_ahi, wr_alo, wr_ctrl, wr_stat, wr_ien;

    rtc_write_engine #(.LATENCY(LATENCY), .AW(AW), .DW(DW)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (bus_sel && bus_wr),
        .req_addr   (bus_addr),
        .req_data   (bus_wdata),
        .busy       (eng_busy),
        .commit     (eng_commit),
        .commit_addr(eng_addr),
        .commit_data(eng_data),
        .next_evt   (eng_next),
        .reject_evt (eng_reject)
    );

    assign wr_tsec  = eng_commit && (eng_addr == AW'(IDX_TSEC));
    assign wr_tfrac = eng_commit && (eng_addr == AW'(IDX_TFRAC));
    assign wr_ahi   = eng_commit && (eng_addr == AW'(IDX_AHI));
    assign wr_alo   = eng_commit && (eng_addr == AW'(IDX_ALO));
    assign wr_ctrl  = eng_commit && (eng_addr == AW'(IDX_CTRL));
    assign wr_stat  = eng_commit && (eng_addr == AW'(IDX_STAT));
    assign wr_ien   = eng_commit && (eng_addr == AW'(IDX_IEN));

    rtc_timebase #(.DW(DW)) u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .run_en   (ctrl_run_q && !flag_nv),
        .invalid  (flag_nv),
        .load_sec (wr_tsec),
        .load_frac(wr_tfrac),
        .wdata    (eng_data),
        .sec_q    (time_sec),
        .frac_q   (time_frac),
        .armed_q  (time_armed)
    );

    assign alarm_hit = (time_sec == alarm_hi_q) && (time_frac == alarm_lo_q)
                     && (alarm_hi_q != '1);

    rtc_status_regs #(.DW(DW)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (eng_commit),
        .stat_wr   (wr_stat),
        .wdata     (eng_data),
        .next_evt  (eng_next),
        .reject_evt(eng_reject),
        .alarm_hit (alarm_hit),
        .violation (violation_in),
        .f_next    (flag_next),
        .f_done    (flag_done),
        .f_err     (flag_err),
        .f_alarm   (flag_alarm),
        .f_nv      (flag_nv),
        .f_sv      (flag_sv)
    );

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_run_q <= 1'b0;
            alarm_hi_q <= '1;
            alarm_lo_q <= '0;
            ien_q      <= '0;
        end else begin
            if (wr_ctrl) ctrl_run_q <= eng_data[B_RUN];
            if (wr_ahi)  alarm_hi_q <= eng_data;
            if (wr_alo)  alarm_lo_q <= eng_data;
            if (wr_ien)  ien_q      <= eng_data & IEN_MASK;
        end
    end

    always_comb begin
        stat_word          = '0;
        stat_word[B_BUSY]  = eng_busy;
        stat_word[B_NEXT]  = flag_next;
        stat_word[B_DONE]  = flag_done;
        stat_word[B_ERR]   = flag_err;
        stat_word[B_ALARM] = flag_alarm;
        stat_word[B_NV]    = flag_nv;
        stat_word[B_SV]    = flag_sv;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(IDX_TSEC):  bus_rdata = time_sec;
            AW'(IDX_TFRAC): bus_rdata = time_frac;
            AW'(IDX_AHI):   bus_rdata = alarm_hi_q;
            AW'(IDX_ALO):   bus_rdata = alarm_lo_q;
            AW'(IDX_CTRL):  bus_rdata = DW'(ctrl_run_q) << B_RUN;
            AW'(IDX_STAT):  bus_rdata = stat_word;
            AW'(IDX_IEN):   bus_rdata = ien_q;
            default:        bus_rdata = '0;
        endcase
    end

    assign irq = (flag_next && ien_q[B_NEXT]) || (flag_done && ien_q[B_DONE])
              || (flag_err && ien_q[B_ERR]) || (flag_alarm && ien_q[B_ALARM]);

endmodule

// File: rtl/rtc_keeper_sva.sv
module rtc_keeper_sva
    import rtc_keeper_pkg::*;
#(
    parameter int DW = 32,
    parameter int LATENCY = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic          tick_en,
    input logic          busy,
    input logic          commit,
    input logic          f_done,
    input logic          f_err,
    input logic          f_alarm,
    input logic          f_nv,
    input logic          armed,
    input logic          run_bit,
    input logic [DW-1:0] sec,
    input logic [DW-1:0] frac,
    input logic [DW-1:0] ahi,
    input logic [DW-1:0] alo,
    input logic [DW-1:0] ien,
    input logic          irq
);

    localparam int RW = $clog2(LATENCY + 2);
    logic [RW-1:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_run <= '0;
        else if (busy && busy_run < RW'(LATENCY + 1)) busy_run <= busy_run + RW'(1);
        else if (!busy) busy_run <= '0;
    end

    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < RW'(LATENCY))); // R2

    AST_DONE_ON_LANDING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_done) |-> $fell(busy)); // R3

    AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && busy) |=> f_err); // R4

    AST_FROZEN_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        ((!armed || f_nv || !run_bit) && !commit) |=> ($stable(frac) && $stable(sec))); // R7

    AST_WRAP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && run_bit && armed && !f_nv && !commit && frac == '1)
        |=> (sec == $past(sec) + DW'(1))); // R8

    AST_ALARM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (sec == ahi && frac == alo && ahi != '1) |=> f_alarm); // R9

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq); // R10

endmodule

bind rtc_keeper rtc_keeper_sva #(.DW(DW), .LATENCY(LATENCY)) u_sva (
    .clk    (clk),
    .rst_n  (rst_n),
    .bus_sel(bus_sel),
    .bus_wr (bus_wr),
    .tick_en(tick_en),
    .busy   (eng_busy),
    .commit (eng_commit),
    .f_done (flag_done),
    .f_err  (flag_err),
    .f_alarm(flag_alarm),
    .f_nv   (flag_nv),
    .armed  (time_armed),
    .run_bit(ctrl_run_q),
    .sec    (time_sec),
    .frac   (time_frac),
    .ahi    (alarm_hi_q),
    .alo    (alarm_lo_q),
    .ien    (ien_q),
    .irq    (irq)
);

// File: tb/rtc_keeper_test.sv
module rtc_keeper_test;

    localparam int CLK_PERIOD = 10;
    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_en = 1'b0;
    logic        violation_in = 1'b0;
    logic        irq;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;

    rtc_keeper uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_en(tick_en), .violation_in(violation_in), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // expected read-back of a written word
    function automatic logic [31:0] exp_readback(input logic [2:0] a, input logic [31:0] d);
        case (a)
            3'd4:    return d & 32'h0000_0008;
            3'd6:    return d & 32'h0000_0390;
            3'd7:    return 32'h0;
            default: return d;
        endcase
    endfunction

    function automatic logic [31:0] stat_of(input bit busy, input bit nx, input bit dn,
                                            input bit er, input bit al, input bit nv, input bit sv);
        return {21'd0, busy, nx, dn, er, 2'b00, al, 2'b00, nv, sv};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wr_raw(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_raw(a, d);
        repeat (LAT) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd5, v); check("R1", "status", v, 32'h0000_0002);
        rd(3'd4, v); check("R1", "control", v, 32'h0);
        rd(3'd6, v); check("R1", "ien", v, 32'h0);
        rd(3'd2, v); check("R1", "alarm hi", v, 32'hFFFF_FFFF);
        rd(3'd0, v); check("R1", "seconds", v, 32'h0);
        check("R1", "irq", {31'd0, irq}, 32'h0);

        // R2 R3 landing timeline
        wr_raw(3'd3, 32'h55);
        rd(3'd5, v); check("R2", "busy after accept", v, stat_of(1, 0, 0, 0, 0, 1, 0));
        rd(3'd3, v); check("R2", "not landed yet", v, 32'h0);
        repeat (2) @(negedge clk);
        rd(3'd5, v); check("R3", "no next yet", v, stat_of(1, 0, 0, 0, 0, 1, 0));
        @(negedge clk);
        rd(3'd5, v); check("R3", "next before landing", v, stat_of(1, 1, 0, 0, 0, 1, 0));
        rd(3'd3, v); check("R2", "still old", v, 32'h0);
        @(negedge clk);
        rd(3'd5, v); check("R3", "complete on landing", v, stat_of(0, 1, 1, 0, 0, 1, 0));
        rd(3'd3, v); check("R2", "landed value", v, 32'h55);

        // R5 clear next and complete
        wr(3'd5, 32'h300);
        rd(3'd5, v); check("R5", "w1c next+done", v, stat_of(0, 0, 0, 0, 0, 1, 0));

        // R6 non-valid needs both bits
        wr(3'd5, 32'h2);
        rd(3'd5, v); check("R6", "nv kept", v & 32'h3, 32'h2);
        wr(3'd5, 32'h3);
        rd(3'd5, v); check("R6", "nv cleared", v & 32'h3, 32'h0);

        // R7 frozen until seconds written
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, v); check("R11", "control keeps bit 3", v, 32'h8);
        ticks(10);
        rd(3'd1, v); check("R7", "frozen before seconds write", v, 32'h0);
        wr(3'd0, 32'h0);
        ticks(5);
        rd(3'd1, v); check("R8", "fraction counts ticks", v, 32'h5);
        wr(3'd4, 32'h0);
        ticks(5);
        rd(3'd1, v); check("R7", "run bit clear freezes", v, 32'h5);
        wr(3'd4, 32'h8);

        // R8 wrap
        wr(3'd1, 32'hFFFF_FFFE);
        wr(3'd0, 32'h7);
        ticks(2);
        rd(3'd0, v); check("R8", "carry into seconds", v, 32'h8);
        rd(3'd1, v); check("R8", "fraction wrapped", v, 32'h0);

        // R4 random second-write gaps
        for (int i = 0; i < 10; i++) begin
            int gap;
            logic [31:0] d1, d2;
            bit rej;
            gap = $urandom_range(0, 4);
            d1 = $urandom;
            d2 = $urandom;
            rej = (gap <= LAT - 2);
            wr_raw(3'd3, d1);
            repeat (gap) @(negedge clk);
            wr_raw(3'd3, d2);
            repeat (LAT + 2) @(negedge clk);
            rd(3'd3, v); check("R4", "pending write value", v, rej ? d1 : d2);
            rd(3'd5, v); check("R4", "error flag", {31'd0, v[7]}, {31'd0, rej});
            wr(3'd5, 32'h80);
            rd(3'd5, v); check("R5", "error cleared", {31'd0, v[7]}, 32'h0);
        end

        // R11 random read-back
        for (int i = 0; i < 12; i++) begin
            logic [2:0] a;
            logic [31:0] d;
            case ($urandom_range(0, 4))
                0: a = 3'd1;
                1: a = 3'd2;
                2: a = 3'd3;
                3: a = 3'd4;
                default: a = 3'd6;
            endcase
            d = $urandom;
            wr(a, d);
            rd(a, v); check("R11", "readback", v, exp_readback(a, d));
        end
        wr(3'd6, 32'h0);
        wr(3'd4, 32'h8);
        wr(3'd2, 32'hFFFF_FFFF);

        // R9 alarm match
        wr(3'd3, 32'h3);
        wr(3'd0, 32'h5);
        wr(3'd1, 32'h0);
        wr(3'd2, 32'h5);
        wr(3'd5, 32'h10);
        rd(3'd5, v); check("R9", "alarm clear before match", {31'd0, v[4]}, 32'h0);
        ticks(3);
        @(negedge clk);
        rd(3'd5, v); check("R9", "alarm on match", {31'd0, v[4]}, 32'h1);
        wr(3'd6, 32'h10);
        check("R10", "irq from alarm", {31'd0, irq}, 32'h1);
        wr(3'd6, 32'h0);
        check("R10", "irq masked", {31'd0, irq}, 32'h0);

        // R9 disabled alarm
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd3, 32'h0);
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd1, 32'h0);
        wr(3'd5, 32'h10);
        repeat (3) @(negedge clk);
        rd(3'd5, v); check("R9", "all-ones alarm disabled", {31'd0, v[4]}, 32'h0);

        // R10 interrupt combining
        wr(3'd6, 32'h100);
        check("R10", "irq from complete", {31'd0, irq}, 32'h1);
        wr(3'd6, 32'h80);
        check("R10", "irq error not set", {31'd0, irq}, 32'h0);
        wr(3'd6, 32'h0);

        // R11 unmapped address
        wr(3'd5, 32'h100);
        rd(3'd5, v); check("R5", "complete cleared", {31'd0, v[8]}, 32'h0);
        wr(3'd7, 32'h1234);
        rd(3'd5, v); check("R11", "unmapped completes", {31'd0, v[8]}, 32'h1);
        rd(3'd7, v); check("R11", "unmapped reads zero", v, 32'h0);

        // R6 R7 violation and re-arm
        wr(3'd1, 32'h0);
        wr(3'd0, 32'h14);
        @(negedge clk);
        violation_in = 1'b1;
        @(negedge clk);
        violation_in = 1'b0;
        rd(3'd5, v); check("R6", "violation sets nv+sv", v & 32'h3, 32'h3);
        ticks(4);
        rd(3'd1, v); check("R7", "invalid freezes", v, 32'h0);
        wr(3'd5, 32'h1);
        rd(3'd5, v); check("R6", "sv alone cleared", v & 32'h3, 32'h2);
        wr(3'd5, 32'h3);
        ticks(4);
        rd(3'd1, v); check("R7", "unarmed after revalidation", v, 32'h0);
        wr(3'd0, 32'h14);
        ticks(4);
        rd(3'd1, v); check("R7", "counts after seconds write", v, 32'h4);

        finish_run();
    end

endmodule